// File: doc/BRIEF.md
# Paired Byte/Word CPU Register File

This block is the architectural register store of a small 8-bit processor core. It keeps eight byte registers (accumulator, flags and six general registers), a 16-bit stack pointer and a 16-bit program counter. The four byte pairs can also be reached as 16-bit words. Both views use one set of flops, so a byte write shows up in a pair read and the reverse. No shadow copy has to be kept in step.

Two independent read ports are combinational. One write port commits on the rising clock edge. Every port has a 3-bit selector and a width bit (0 = byte, 1 = pair/word). The low nibble of the flag register does not exist in storage, so it always reads as zero, whatever the write path. An asynchronous active-low reset loads the program counter and the stack pointer with their start values and clears every byte register.

The core's decoder drives the selectors. The ALU consumes the read data and returns results through the write port.

Top module: `pair_regfile`

## Requirements
- R1: Byte reads (width bit 0) use the selector encoding 0=A, 1=F, 2=B, 3=C, 4=D, 5=E, 6=H, 7=L. The register appears on data bits 7..0, and bits 15..8 read as zero. A byte write uses `wr_data[7:0]`.
- R2: Pair reads and writes (width bit 1) use 0=AF, 1=BC, 2=DE, 3=HL. The first-named register sits in bits 15..8 and the second in bits 7..0. After a pair write, each half reads back as the new byte from the next cycle on.
- R3: A byte write to A, F, B, C, D, E, H or L changes the matching half of its pair as seen by a pair read, and leaves the other half unchanged.
- R4: Bits 3..0 of F read as zero after any write, byte or pair (AF). Bits 7..4 keep the flag values written (Z bit 7, N bit 6, H bit 5, C bit 4).
- R5: While reset is active, and after its release until the first write, the program counter reads 0x0000, the stack pointer reads 0xFFFE and every byte register reads 0x00.
- R6: In pair width, selector 4 reads and writes the 16-bit stack pointer and selector 5 the 16-bit program counter.
- R7: In pair width, selectors 6 and 7 read as 0x0000, and a write to them changes no register.
- R8: Reads are combinational. A write becomes visible only after the rising clock edge that commits it, so a read of the same register in the writing cycle returns the old value. With the write enable low, no register changes.
- R9: The two read ports select independently, and each returns its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd0_sel | input | 3 | Read port 0 register selector |
| rd0_wide | input | 1 | Read port 0 width: 0 byte, 1 pair/word |
| rd0_data | output | 16 | Read port 0 data |
| rd1_sel | input | 3 | Read port 1 register selector |
| rd1_wide | input | 1 | Read port 1 width: 0 byte, 1 pair/word |
| rd1_data | output | 16 | Read port 1 data |
| wr_en | input | 1 | Write enable |
| wr_sel | input | 3 | Write register selector |
| wr_wide | input | 1 | Write width: 0 byte, 1 pair/word |
| wr_data | input | 16 | Write data |

## Verification
A write and a combinational read of the same storage can fall in the same cycle. So can a pair write and the flag masking of its low byte. The bench provokes the first by driving a pair write to BC together with a pair read of BC in one cycle. It expects the old word before the edge and the new word after it. The second is covered by full sweeps of byte and pair writes over all selectors. After each write, every byte and pair view on both ports is compared with a model in the bench that clears the flag nibble.

// File: rtl/rf_pkg.sv
package rf_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 2 * BYTE_W;
    localparam int NUM_BYTES = 8;
    localparam int NUM_PAIRS = NUM_BYTES / 2;
    localparam int SEL_W     = $clog2(NUM_BYTES);
    localparam int FLAG_KEEP = 4;

    typedef logic [SEL_W-1:0] sel_t;
    typedef logic [NUM_BYTES-1:0][BYTE_W-1:0] bytes_t;

    localparam sel_t BYTE_FLAGS = sel_t'(1);
    localparam sel_t WORD_SP    = sel_t'(4);
    localparam sel_t WORD_PC    = sel_t'(5);
endpackage

// File: rtl/rf_write_steer.sv
module rf_write_steer
    import rf_pkg::*;
(
    input  logic                 wr_en,
    input  sel_t                 wr_sel,
    input  logic                 wr_wide,
    input  logic [WORD_W-1:0]    wr_data,
    output logic [NUM_BYTES-1:0] byte_we,
    output bytes_t               byte_wd,
    output logic                 sp_we,
    output logic                 pc_we
);
    always_comb begin
        byte_we = '0;
        byte_wd = '0;
        sp_we   = 1'b0;
        pc_we   = 1'b0;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (wr_en && !wr_wide && wr_sel == sel_t'(i)) begin
                byte_we[i] = 1'b1;
                byte_wd[i] = wr_data[BYTE_W-1:0];
            end
            if (wr_en && wr_wide && wr_sel == sel_t'(i / 2)) begin
                byte_we[i] = 1'b1;
                byte_wd[i] = (i % 2 == 0) ? wr_data[WORD_W-1:BYTE_W]
                                          : wr_data[BYTE_W-1:0];
            end
        end
        if (wr_en && wr_wide && wr_sel == WORD_SP) sp_we = 1'b1;
        if (wr_en && wr_wide && wr_sel == WORD_PC) pc_we = 1'b1;
    end
endmodule

// File: rtl/rf_bank.sv
module rf_bank
    import rf_pkg::*;
#(
    parameter logic [WORD_W-1:0] RESET_SP = 16'hFFFE,
    parameter logic [WORD_W-1:0] RESET_PC = 16'h0000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BYTES-1:0] byte_we,
    input  bytes_t               byte_wd,
    input  logic                 sp_we,
    input  logic                 pc_we,
    input  logic [WORD_W-1:0]    word_wd,
    output bytes_t               bytes_q,
    output logic [WORD_W-1:0]    sp_q,
    output logic [WORD_W-1:0]    pc_q
);
    localparam int FLAG_DROP = BYTE_W - FLAG_KEEP;

    for (genvar i = 0; i < NUM_BYTES; i++) begin : g_byte
        if (sel_t'(i) == BYTE_FLAGS) begin : g_flags
            logic [FLAG_KEEP-1:0] flag_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          flag_q <= '0;
                else if (byte_we[i]) flag_q <= byte_wd[i][BYTE_W-1:FLAG_DROP];
            end
            assign bytes_q[i] = {flag_q, {FLAG_DROP{1'b0}}};
        end else begin : g_plain
            logic [BYTE_W-1:0] val_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)          val_q <= '0;
                else if (byte_we[i]) val_q <= byte_wd[i];
            end
            assign bytes_q[i] = val_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= RESET_SP;
            pc_q <= RESET_PC;
        end else begin
            if (sp_we) sp_q <= word_wd;
            if (pc_we) pc_q <= word_wd;
        end
    end
endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
    import rf_pkg::*;
(
    input  sel_t              sel,
    input  logic              wide,
    input  bytes_t            bytes_q,
    input  logic [WORD_W-1:0] sp_q,
    input  logic [WORD_W-1:0] pc_q,
    output logic [WORD_W-1:0] data
);
    localparam int PAIR_W = $clog2(NUM_PAIRS);

    logic [PAIR_W-1:0] pair_idx;
    assign pair_idx = sel[PAIR_W-1:0];

    always_comb begin
        data = '0;
        if (!wide) begin
            data = {{BYTE_W{1'b0}}, bytes_q[sel]};
        end else if (int'(sel) < NUM_PAIRS) begin
            data = {bytes_q[{pair_idx, 1'b0}], bytes_q[{pair_idx, 1'b1}]};
        end else if (sel == WORD_SP) begin
            data = sp_q;
        end else if (sel == WORD_PC) begin
            data = pc_q;
        end
    end
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
    import rf_pkg::*;
#(
    parameter logic [15:0] RESET_SP = 16'hFFFE,
    parameter logic [15:0] RESET_PC = 16'h0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  rd0_sel,
    input  logic        rd0_wide,
    output logic [15:0] rd0_data,
    input  logic [2:0]  rd1_sel,
    input  logic        rd1_wide,
    output logic [15:0] rd1_data,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic        wr_wide,
    input  logic [15:0] wr_data
);
    localparam int NUM_RD = 2;

    logic [NUM_BYTES-1:0] byte_we;
    bytes_t               byte_wd;
    logic                 sp_we;
    logic                 pc_we;
    bytes_t               bytes_q;
    logic [WORD_W-1:0]    sp_q;
    logic [WORD_W-1:0]    pc_q;

    sel_t                    rsel  [NUM_RD];
    logic [NUM_RD-1:0]       rwide;
    logic [WORD_W-1:0]       rdata [NUM_RD];

    assign rsel[0]  = rd0_sel;
    assign rsel[1]  = rd1_sel;
    assign rwide    = {rd1_wide, rd0_wide};
    assign rd0_data = rdata[0];
    assign rd1_data = rdata[1];

    rf_write_steer i_steer (
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_wide (wr_wide),
        .wr_data (wr_data),
        .byte_we (byte_we),
        .byte_wd (byte_wd),
        .sp_we   (sp_we),
        .pc_we   (pc_we)
    );

    rf_bank #(
        .RESET_SP (RESET_SP),
        .RESET_PC (RESET_PC)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .byte_we (byte_we),
        .byte_wd (byte_wd),
        .sp_we   (sp_we),
        .pc_we   (pc_we),
        .word_wd (wr_data),
        .bytes_q (bytes_q),
        .sp_q    (sp_q),
        .pc_q    (pc_q)
    );

    for (genvar p = 0; p < NUM_RD; p++) begin : g_rd
        rf_read_port i_rd (
            .sel     (rsel[p]),
            .wide    (rwide[p]),
            .bytes_q (bytes_q),
            .sp_q    (sp_q),
            .pc_q    (pc_q),
            .data    (rdata[p])
        );
    end
endmodule

// File: rtl/rf_checker.sv
module rf_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  rd0_sel,
    input logic        rd0_wide,
    input logic [15:0] rd0_data,
    input logic [2:0]  rd1_sel,
    input logic        rd1_wide,
    input logic [15:0] rd1_data,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic        wr_wide,
    input logic [15:0] wr_data
);
    // R1
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd0_wide || !rd1_wide) |->
        ((rd0_wide || rd0_data[15:8] == 8'h00) && (rd1_wide || rd1_data[15:8] == 8'h00)));

    // R4
    flag_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_sel == 3'd0 && rd0_wide) || (rd0_sel == 3'd1 && !rd0_wide) |->
        rd0_data[3:0] == 4'h0);

    // R7
    unused_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_wide && rd0_sel[2:1] == 2'b11) |-> rd0_data == 16'h0000);

    // R2
    pair_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_wide && wr_sel == 3'd3) |=>
        ((!rd0_wide && rd0_sel == 3'd6) ? (rd0_data == {8'h00, $past(wr_data[15:8])}) : 1'b1));

    // R8
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=>
        (($stable(rd0_sel) && $stable(rd0_wide)) ? $stable(rd0_data) : 1'b1));

    // R5
    reset_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!rst_n) && rd0_wide && rd0_sel == 3'd5) |-> rd0_data == 16'h0000);
endmodule

bind pair_regfile rf_checker i_rf_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd0_sel  (rd0_sel),
    .rd0_wide (rd0_wide),
    .rd0_data (rd0_data),
    .rd1_sel  (rd1_sel),
    .rd1_wide (rd1_wide),
    .rd1_data (rd1_data),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_wide  (wr_wide),
    .wr_data  (wr_data)
);

// File: tb/test_pair_regfile.sv
module test_pair_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  rd0_sel = '0, rd1_sel = '0, wr_sel = '0;
    logic        rd0_wide = 1'b0, rd1_wide = 1'b0, wr_wide = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd0_data, rd1_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0]  m_byte [8];
    logic [15:0] m_sp, m_pc;

    always #2 clk = ~clk;

    pair_regfile i_pair_regfile (
        .clk(clk), .rst_n(rst_n),
        .rd0_sel(rd0_sel), .rd0_wide(rd0_wide), .rd0_data(rd0_data),
        .rd1_sel(rd1_sel), .rd1_wide(rd1_wide), .rd1_data(rd1_data),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_wide(wr_wide), .wr_data(wr_data)
    );

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_byte[i] = 8'h00;
        m_sp = 16'hFFFE;
        m_pc = 16'h0000;
    endtask

    function automatic logic [15:0] exp_read(logic [2:0] s, logic w);
        if (!w)            return {8'h00, m_byte[s]};
        if (s < 3'd4)      return {m_byte[2*s], m_byte[2*s+1]};
        if (s == 3'd4)     return m_sp;
        if (s == 3'd5)     return m_pc;
        return 16'h0000;
    endfunction

    task automatic model_write(logic [2:0] s, logic w, logic [15:0] d);
        if (!w) m_byte[s] = d[7:0];
        else if (s < 3'd4) begin
            m_byte[2*s]   = d[15:8];
            m_byte[2*s+1] = d[7:0];
        end else if (s == 3'd4) m_sp = d;
        else if (s == 3'd5) m_pc = d;
        m_byte[1][3:0] = 4'h0;
    endtask

    function automatic string tag_of(logic [2:0] s, logic w, string extra);
        string t;
        if (!w)                t = (s == 3'd1) ? "R1/R4" : "R1";
        else if (s == 3'd0)    t = "R2/R4";
        else if (s < 3'd4)     t = "R2";
        else if (s < 3'd6)     t = "R6";
        else                   t = "R7";
        return {t, extra};
    endfunction

    task automatic cmp(logic [15:0] act, logic [15:0] exp, string req);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(string extra);
        for (int s = 0; s < 8; s++) begin
            for (int w = 0; w < 2; w++) begin
                rd0_sel = 3'(s); rd0_wide = 1'(w);
                rd1_sel = 3'(7 - s); rd1_wide = 1'(w);
                #1;
                cmp(rd0_data, exp_read(3'(s), 1'(w)), tag_of(3'(s), 1'(w), extra));
                cmp(rd1_data, exp_read(3'(7 - s), 1'(w)), {tag_of(3'(7 - s), 1'(w), extra), "/R9"});
            end
        end
    endtask

    task automatic do_write(logic [2:0] s, logic w, logic [15:0] d, logic en);
        @(negedge clk);
        wr_sel = s; wr_wide = w; wr_data = d; wr_en = en;
        @(posedge clk);
        if (en) model_write(s, w, d);
        #1 wr_en = 1'b0;
    endtask

    initial begin
        model_reset();
        #5;
        check_all(" reset R5");
        @(negedge clk) rst_n = 1'b1;
        check_all(" after release R5");

        // byte writes land in pairs (R3)
        for (int r = 0; r < 3; r++)
            for (int s = 0; s < 8; s++) begin
                do_write(3'(s), 1'b0, {8'hC3, 8'(s * 29 + r * 83 + 17)}, 1'b1);
                check_all(" byte write R3");
            end

        // pair and word writes, including unused selectors (R2, R4, R6, R7)
        for (int r = 0; r < 3; r++)
            for (int s = 0; s < 8; s++) begin
                do_write(3'(s), 1'b1, 16'(s * 4099 + r * 12345 + 16'hA5C3), 1'b1);
                check_all(" pair write");
            end

        // flag pattern sweep through AF (R4)
        for (int v = 0; v < 16; v++) begin
            do_write(3'd0, 1'b1, {8'h3C, 4'(v), 4'hF}, 1'b1);
            rd0_sel = 3'd1; rd0_wide = 1'b0; #1;
            cmp(rd0_data, {8'h00, 4'(v), 4'h0}, "R4 flag byte");
        end

        // write with enable low has no effect (R8)
        do_write(3'd2, 1'b1, 16'h1234, 1'b0);
        do_write(3'd7, 1'b0, 16'h00EE, 1'b0);
        check_all(" idle R8");

        // same-cycle write and read of BC (R8)
        @(negedge clk);
        rd0_sel = 3'd1; rd0_wide = 1'b1;
        wr_sel = 3'd1; wr_wide = 1'b1; wr_data = 16'hBEEF; wr_en = 1'b1;
        #1 cmp(rd0_data, exp_read(3'd1, 1'b1), "R8 old value before edge");
        @(posedge clk);
        model_write(3'd1, 1'b1, 16'hBEEF);
        #1 wr_en = 1'b0;
        cmp(rd0_data, 16'hBEEF, "R8 new value after edge");
        check_all(" after collision R8");

        // reset mid-run (R5)
        @(negedge clk) rst_n = 1'b0;
        model_reset();
        check_all(" mid-run reset R5");
        @(negedge clk) rst_n = 1'b1;

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule